// File: doc/BRIEF.md
# Address Security Attribution Unit

This block assigns fixed security attributes to addresses in a 32-bit space. A request carries a lookup address. One clock later the unit returns four registered results: the 256 MB region the address falls in, whether that region is non-secure, whether it is non-secure-callable, and whether the address lies in one of the two exempt windows at the top of the map. Most of the answer comes from fixed rules on the address bits. Only the non-secure-callable flag depends on runtime state.

That state is a 2-bit configuration register. A security controller drives a level onto `cfg_in` and strobes `cfg_load`. Each bit of the register enables one secure region as callable: bit 0 enables region 1 and bit 1 enables region 3. Reset clears the register, so no region is callable after reset. Lookups can be issued on every cycle. Between requests the outputs keep the last result.

Top module: `sec_attr_unit`

## Requirements
- R1: For each accepted request, `region_out` equals bits [31:28] of the request address, whatever the values of the other flags.
- R2: `nonsec_out` is 1 exactly when bit 28 of the request address is 0. Regions with an odd identifier are secure (`nonsec_out` = 0).
- R3: `callable_out` is 1 only when the region is 1 and configuration bit 0 is set, or when the region is 3 and configuration bit 1 is set. It is 0 in every other case.
- R4: `exempt_out` is 1 exactly when (address AND 0xEFF00000) equals 0xE0000000. These are the windows 0xE0000000–0xE00FFFFF and 0xF0000000–0xF00FFFFF.
- R5: After reset the configuration register holds 0, so lookups in regions 1 and 3 report `callable_out` = 0.
- R6: The configuration register captures `cfg_in[1:0]` on a clock edge where `cfg_load` is 1. Bits above bit 1 of `cfg_in` have no effect. A lookup whose request edge is the capture edge uses the old value. Lookups at later edges use the new value.
- R7: `valid_out` is 1 in exactly the cycle after a request edge with `req` = 1. Requests on consecutive cycles each produce their own result on consecutive cycles.
- R8: Reset is synchronous and active high. After a reset edge, `valid_out`, `region_out`, `nonsec_out`, `callable_out` and `exempt_out` are all 0.
- R9: The flags are evaluated independently. An exempt address still reports its region and the bit-28 non-secure rule: for example, 0xE... is non-secure and 0xF... is secure.
- R10: While `valid_out` is 0 (and no reset intervened), the four result outputs hold the values of the last result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| cfg_load | input | 1 | Load strobe for the configuration register |
| cfg_in | input | CFG_IN_W | Configuration level from the security controller; only bits [1:0] are used |
| req | input | 1 | Lookup request, sampled with `addr` |
| addr | input | ADDR_W | Lookup address |
| valid_out | output | 1 | Result valid, one cycle after a request |
| region_out | output | 4 | Region identifier (address bits [31:28]) |
| nonsec_out | output | 1 | Address is non-secure |
| callable_out | output | 1 | Address is non-secure-callable |
| exempt_out | output | 1 | Address is in an exempt window |

## Verification
The assertions assume that `rst` is held high from time zero through at least one rising edge. They also assume that `addr`, `req`, `cfg_load` and `cfg_in` are stable at each rising edge, because several properties compare a result with `$past` of the request inputs. The stimulus changes every input only on the falling edge. The random traffic mixes requests, gaps, configuration loads with random upper bits, and occasional resets. It biases addresses toward regions 1, 3, 0xE and 0xF so that the callable and exempt boundaries are hit often.

// File: rtl/sau_pkg.sv
package sau_pkg;
  localparam int ADDR_W   = 32;
  localparam int REGION_W = 4;
  localparam int CFG_W    = 2;

  localparam logic [ADDR_W-1:0] EXEMPT_MASK  = 32'hEFF0_0000;
  localparam logic [ADDR_W-1:0] EXEMPT_MATCH = 32'hE000_0000;

  typedef logic [REGION_W-1:0] region_t;

  typedef struct packed {
    region_t region;
    logic    nonsec;
    logic    callable;
    logic    exempt;
  } attr_t;

  function automatic region_t region_of(input logic [ADDR_W-1:0] a);
    return a[ADDR_W-1 -: REGION_W];
  endfunction

  // low bit of the region id clear means non-secure
  function automatic logic nonsec_of(input region_t r);
    return ~r[0];
  endfunction

  // config bit idx enables odd region 2*idx+1
  function automatic region_t callable_region(input int unsigned idx);
    return region_t'(2 * idx + 1);
  endfunction

  function automatic logic exempt_of(input logic [ADDR_W-1:0] a);
    return (a & EXEMPT_MASK) == EXEMPT_MATCH;
  endfunction
endpackage

// File: rtl/sau_cfg_reg.sv
module sau_cfg_reg
  import sau_pkg::*;
#(
  parameter int CFG_IN_W = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                load,
  input  logic [CFG_IN_W-1:0] cfg_in,
  output logic [CFG_W-1:0]    cfg_q
);
  generate
    if (CFG_IN_W > CFG_W) begin : g_hi
      logic unused_hi;
      assign unused_hi = ^cfg_in[CFG_IN_W-1:CFG_W];
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q <= '0;
    end else if (load) begin
      cfg_q <= cfg_in[CFG_W-1:0];
    end
  end
endmodule

// File: rtl/sau_attr_decode.sv
module sau_attr_decode
  import sau_pkg::*;
(
  input  logic [ADDR_W-1:0] addr,
  input  logic [CFG_W-1:0]  cfg,
  output logic [CFG_W-1:0]  call_hit,
  output attr_t             attr
);
  region_t reg_id;
  assign reg_id = region_of(addr);

  genvar i;
  generate
    for (i = 0; i < CFG_W; i++) begin : g_call
      assign call_hit[i] = cfg[i] && (reg_id == callable_region(i));
    end
  endgenerate

  always_comb begin
    attr.region   = reg_id;
    attr.nonsec   = nonsec_of(reg_id);
    attr.callable = |call_hit;
    attr.exempt   = exempt_of(addr);
  end
endmodule

// File: rtl/sau_out_reg.sv
module sau_out_reg
  import sau_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  req,
  input  attr_t attr_in,
  output logic  valid_q,
  output attr_t attr_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q <= 1'b0;
      attr_q  <= '0;
    end else begin
      valid_q <= req;
      if (req) begin
        attr_q <= attr_in;
      end
    end
  end
endmodule

// File: rtl/sec_attr_unit.sv
module sec_attr_unit
  import sau_pkg::*;
#(
  parameter int CFG_IN_W = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                cfg_load,
  input  logic [CFG_IN_W-1:0] cfg_in,
  input  logic                req,
  input  logic [ADDR_W-1:0]   addr,
  output logic                valid_out,
  output logic [REGION_W-1:0] region_out,
  output logic                nonsec_out,
  output logic                callable_out,
  output logic                exempt_out
);
  logic [CFG_W-1:0] cfg_q;
  logic [CFG_W-1:0] call_hit;
  attr_t            lookup_attr;
  attr_t            result_attr;

  sau_cfg_reg #(.CFG_IN_W(CFG_IN_W)) u_cfg (
    .clk    (clk),
    .rst    (rst),
    .load   (cfg_load),
    .cfg_in (cfg_in),
    .cfg_q  (cfg_q)
  );

  sau_attr_decode u_dec (
    .addr     (addr),
    .cfg      (cfg_q),
    .call_hit (call_hit),
    .attr     (lookup_attr)
  );

  sau_out_reg u_out (
    .clk     (clk),
    .rst     (rst),
    .req     (req),
    .attr_in (lookup_attr),
    .valid_q (valid_out),
    .attr_q  (result_attr)
  );

  assign region_out   = result_attr.region;
  assign nonsec_out   = result_attr.nonsec;
  assign callable_out = result_attr.callable;
  assign exempt_out   = result_attr.exempt;
endmodule

// File: rtl/sau_checker.sv
module sau_checker
  import sau_pkg::*;
#(
  parameter int CFG_IN_W = 8
) (
  input logic                clk,
  input logic                rst,
  input logic                cfg_load,
  input logic [CFG_IN_W-1:0] cfg_in,
  input logic                req,
  input logic [ADDR_W-1:0]   addr,
  input logic                valid_out,
  input logic [REGION_W-1:0] region_out,
  input logic                nonsec_out,
  input logic                callable_out,
  input logic                exempt_out,
  input logic [CFG_W-1:0]    cfg_q
);
  a_r7_valid_follows_req: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> valid_out == $past(req));

  a_r1_region_from_addr: assert property (@(posedge clk) disable iff (rst)
    valid_out |-> region_out == $past(addr[31:28]));

  a_r2_nonsec_bit28: assert property (@(posedge clk) disable iff (rst)
    valid_out |-> nonsec_out == !$past(addr[28]));

  a_r3_callable_rule: assert property (@(posedge clk) disable iff (rst)
    valid_out |-> callable_out ==
      (($past(addr[31:28]) == 4'd1 && $past(cfg_q[0])) ||
       ($past(addr[31:28]) == 4'd3 && $past(cfg_q[1]))));

  a_r3_callable_secure: assert property (@(posedge clk) disable iff (rst)
    callable_out |-> !nonsec_out);

  a_r4_exempt_window: assert property (@(posedge clk) disable iff (rst)
    valid_out |-> exempt_out ==
      ($past(addr[31:29]) == 3'b111 && $past(addr[27:20]) == 8'h00));

  a_r5_cfg_reset: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> cfg_q == '0);

  a_r6_cfg_capture: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(cfg_load)) |-> cfg_q == $past(cfg_in[1:0]));

  a_r6_cfg_hold: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(cfg_load)) |-> $stable(cfg_q));

  a_r8_reset_clears: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!valid_out && region_out == '0 && !nonsec_out &&
                    !callable_out && !exempt_out));

  a_r10_hold_idle: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !valid_out) |->
      ($stable(region_out) && $stable(nonsec_out) &&
       $stable(callable_out) && $stable(exempt_out)));
endmodule

bind sec_attr_unit sau_checker #(.CFG_IN_W(CFG_IN_W)) u_chk (.*);

// File: tb/sec_attr_unit_test.sv
module sec_attr_unit_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_load = 1'b0;
  logic [7:0]  cfg_in = '0;
  logic        req = 1'b0;
  logic [31:0] addr = '0;
  logic        valid_out;
  logic [3:0]  region_out;
  logic        nonsec_out, callable_out, exempt_out;

  int checks = 0;
  int errors = 0;

  // bench model
  logic        p_rst = 1'b1;
  logic        p_req = 1'b0;
  logic [31:0] p_addr = '0;
  logic [1:0]  p_cfg = '0;
  string       p_tag = "R3";
  logic [1:0]  cur_cfg = '0;
  logic [3:0]  l_region = '0;
  logic        l_nonsec = 1'b0, l_call = 1'b0, l_exempt = 1'b0;

  sec_attr_unit uut (
    .clk(clk), .rst(rst), .cfg_load(cfg_load), .cfg_in(cfg_in),
    .req(req), .addr(addr), .valid_out(valid_out), .region_out(region_out),
    .nonsec_out(nonsec_out), .callable_out(callable_out),
    .exempt_out(exempt_out)
  );

  always #5 clk = ~clk;

  function automatic logic [3:0] e_region(input logic [31:0] a);
    return 4'(a / 32'h1000_0000);
  endfunction
  function automatic logic e_nonsec(input logic [31:0] a);
    return (e_region(a) % 2) == 0;
  endfunction
  function automatic logic e_call(input logic [31:0] a, input logic [1:0] c);
    case (e_region(a))
      4'd1: return c[0];
      4'd3: return c[1];
      default: return 1'b0;
    endcase
  endfunction
  function automatic logic e_exempt(input logic [31:0] a);
    return (a >= 32'hE000_0000 && a <= 32'hE00F_FFFF) ||
           (a >= 32'hF000_0000 && a <= 32'hF00F_FFFF);
  endfunction

  task automatic cmp(input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h (addr=%h)", tag, what, act, exp, p_addr);
    end
  endtask

  task automatic check_pending();
    if (p_rst) begin
      cmp("R8", "valid_out", 32'(valid_out), 0);
      cmp("R8", "region_out", 32'(region_out), 0);
      cmp("R8", "nonsec_out", 32'(nonsec_out), 0);
      cmp("R8", "callable_out", 32'(callable_out), 0);
      cmp("R8", "exempt_out", 32'(exempt_out), 0);
      l_region = '0; l_nonsec = 0; l_call = 0; l_exempt = 0;
    end else begin
      cmp("R7", "valid_out", 32'(valid_out), 32'(p_req));
      if (p_req) begin
        l_region = e_region(p_addr);
        l_nonsec = e_nonsec(p_addr);
        l_call   = e_call(p_addr, p_cfg);
        l_exempt = e_exempt(p_addr);
        cmp(l_exempt ? "R9" : "R1", "region_out", 32'(region_out), 32'(l_region));
        cmp(l_exempt ? "R9" : "R2", "nonsec_out", 32'(nonsec_out), 32'(l_nonsec));
        cmp(p_tag, "callable_out", 32'(callable_out), 32'(l_call));
        cmp("R4", "exempt_out", 32'(exempt_out), 32'(l_exempt));
      end else begin
        cmp("R10", "region_out", 32'(region_out), 32'(l_region));
        cmp("R10", "nonsec_out", 32'(nonsec_out), 32'(l_nonsec));
        cmp("R10", "callable_out", 32'(callable_out), 32'(l_call));
        cmp("R10", "exempt_out", 32'(exempt_out), 32'(l_exempt));
      end
    end
  endtask

  task automatic step(input logic r, input logic q, input logic [31:0] a,
                      input logic ld, input logic [7:0] cv, input string tag);
    @(negedge clk);
    check_pending();
    rst = r; req = q; addr = a; cfg_load = ld; cfg_in = cv;
    p_rst = r; p_req = q && !r; p_addr = a; p_cfg = cur_cfg; p_tag = tag;
    if (r) cur_cfg = '0;
    else if (ld) cur_cfg = cv[1:0];
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL R7 watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : stim
    void'($urandom(32'd20240601));
    step(1, 0, 0, 0, 0, "R3");
    step(1, 1, 32'h1000_0000, 1, 8'hFF, "R3");   // load during reset ignored
    // R5: callable regions off after reset
    step(0, 1, 32'h1234_5678, 0, 0, "R5");
    step(0, 1, 32'h3FFF_FFFF, 0, 0, "R5");
    step(0, 0, 0, 0, 0, "R3");                  // R10 idle hold
    // R6: upper bits ignored, 0xFD loads 2'b01
    step(0, 0, 0, 1, 8'hFD, "R6");
    step(0, 1, 32'h1000_0000, 0, 0, "R6");
    step(0, 1, 32'h3000_0000, 0, 0, "R6");
    // R6: load at same edge as request uses old value
    step(0, 1, 32'h3000_0004, 1, 8'h02, "R6");
    step(0, 1, 32'h3000_0008, 0, 0, "R6");
    step(0, 1, 32'h1000_0008, 0, 0, "R6");
    step(0, 0, 0, 1, 8'h03, "R3");
    step(0, 1, 32'h5000_0000, 0, 0, "R3");      // secure but not callable
    step(0, 1, 32'h0000_0000, 0, 0, "R3");
    step(0, 1, 32'h1FFF_FFFF, 0, 0, "R3");
    // R4 / R9 exempt boundaries
    step(0, 1, 32'hE000_0000, 0, 0, "R3");
    step(0, 1, 32'hE00F_FFFF, 0, 0, "R3");
    step(0, 1, 32'hE010_0000, 0, 0, "R3");
    step(0, 1, 32'hF000_0000, 0, 0, "R3");
    step(0, 1, 32'hF00F_FFFF, 0, 0, "R3");
    step(0, 1, 32'hF010_0000, 0, 0, "R3");
    step(0, 1, 32'hDFFF_FFFF, 0, 0, "R3");
    step(0, 1, 32'h6000_0000, 0, 0, "R3");
    // R8: reset mid-stream clears outputs and config
    step(1, 1, 32'h3000_0000, 0, 0, "R3");
    step(0, 1, 32'h3000_0000, 0, 0, "R5");
    // random traffic
    for (int n = 0; n < 3000; n++) begin
      logic [31:0] a;
      logic [3:0] hot [4];
      hot[0] = 4'h1; hot[1] = 4'h3; hot[2] = 4'hE; hot[3] = 4'hF;
      a = $urandom;
      if ($urandom % 2 == 0) a[31:28] = hot[$urandom % 4];
      if ($urandom % 4 == 0) a[27:20] = ($urandom % 2) ? 8'h00 : 8'hFF;
      step(($urandom % 300) == 0, ($urandom % 4) != 0, a,
           ($urandom % 8) == 0, 8'($urandom), "R3");
    end
    step(0, 0, 0, 0, 0, "R3");
    step(0, 0, 0, 0, 0, "R3");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule